// File: doc/BRIEF.md
# Page Frame Eviction Chooser

This block keeps two history bits for every page frame of a small physical memory: a referenced bit and a dirty bit. Memory accesses are reported to it as strobes carrying a frame number and a write flag. When a page fault arrives, it names one frame whose contents should be evicted. It reports that frame on a victim output together with a one-cycle done pulse. Moving page contents and updating translation tables are left to the surrounding logic.

Two eviction policies are available and are chosen per fault by a mode input. The sweep policy walks a circular pointer over the frames, one frame per cycle. A frame found with its referenced bit set gets a second chance: the bit is cleared and the walk moves on. The class policy ranks frames by their two bits into four preference classes. It then picks inside the best non-empty class, starting the search at a pseudo-random index taken from a free-running shift register. Once a victim is named, both of its bits are cleared, ready for the incoming page.

Top module: `pfr_victim_sel`

## Requirements
- R1: After reset, every referenced and dirty bit is clear, the sweep pointer is at frame 0, `done_o` is low and `victim_o` is 0.
- R2: An access strobe (`acc_valid_i` high) sets the referenced bit of frame `acc_frame_i`. When `acc_write_i` is also high, it sets that frame's dirty bit too. A read access leaves the dirty bit unchanged.
- R3: A fault request is accepted only when the block is idle and `done_o` is low. A request raised while a sweep is in progress is ignored and produces no extra done pulse.
- R4: In sweep mode (`mode_i` = 0 when the request is accepted), the frame under the pointer is examined once per cycle. If its referenced bit is set, that bit is cleared and the pointer moves to the next frame, wrapping from 7 to 0.
- R5: In sweep mode, the victim is the first examined frame whose referenced bit is clear. The dirty bit plays no part in the choice.
- R6: A sweep examines at most 9 frames. `done_o` rises at most 10 cycles after the clock edge that accepts the request.
- R7: In class mode (`mode_i` = 1), candidates are taken from the first non-empty set in this order: frames with both bits clear, frames with the referenced bit clear, frames with the dirty bit clear, and finally all frames.
- R8: Within the chosen set, the victim is the first member met when scanning upward, with wraparound, from a start index. The start index is the low 3 bits of a 16-bit LFSR. The LFSR loads 0xACE1 during reset and shifts left every cycle, with bit 15 XOR bit 13 XOR bit 12 XOR bit 10 entering bit 0. The value used is the one held before the accepting edge.
- R9: In class mode, `done_o` is high in the cycle right after the accepting edge.
- R10: `done_o` lasts exactly one cycle. At the edge that names the victim, both of the victim's bits are cleared and the sweep pointer moves to the frame after the victim, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_frame_i | input | 3 | Frame number of the access |
| acc_write_i | input | 1 | Access is a write |
| mode_i | input | 1 | Policy for the fault being requested: 0 sweep, 1 class |
| fault_req_i | input | 1 | Request an eviction choice |
| victim_o | output | 3 | Chosen frame, valid while done_o is high |
| done_o | output | 1 | One-cycle pulse marking a new victim |

## Verification
Several properties are checked on every cycle. An access sets its bits on the following edge. A sweep victim always had a clear referenced bit just before it was named. A class victim always belongs to the best-ranked class of the bits held the cycle before. The victim's bits read clear while done is high, and done never lasts two cycles. The sweep length and the class-mode latency are checked as well. Only the bench scenarios can show the rest, because that needs a model kept across many faults: the exact frame picked by the pseudo-random scan, the pointer position carried over from one fault to the next, and that a request made during a sweep is dropped.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

   typedef enum logic {
      POL_SWEEP = 1'b0,
      POL_CLASS = 1'b1
   } policy_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_SWEEP = 1'b1
   } sel_state_e;

   typedef enum logic [1:0] {
      CL_COLD  = 2'd0,
      CL_UNREF = 2'd1,
      CL_CLEAN = 2'd2,
      CL_ANY   = 2'd3
   } cand_class_e;

endpackage

// File: rtl/pfr_lfsr.sv
module pfr_lfsr #(
   parameter int unsigned       WIDTH = 16,
   parameter logic [WIDTH-1:0]  SEED  = 16'hACE1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   output logic [WIDTH-1:0] state_o
);

   logic [WIDTH-1:0] taps;
   logic [WIDTH-1:0] state_q;

   generate
      if (WIDTH == 8) begin : g_w8
         assign taps = WIDTH'(8'hB8);
      end else if (WIDTH == 16) begin : g_w16
         assign taps = WIDTH'(16'hB400);
      end else if (WIDTH == 32) begin : g_w32
         assign taps = WIDTH'(32'h8020_0003);
      end else begin : g_bad
         $error("pfr_lfsr: unsupported WIDTH");
         assign taps = '0;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= SEED;
      end else begin
         state_q <= {state_q[WIDTH-2:0], ^(state_q & taps)};
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/pfr_frame_bits.sv
module pfr_frame_bits #(
   parameter int unsigned NUM_FRAMES = 8,
   localparam int unsigned IDX_W     = $clog2(NUM_FRAMES)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  set_en_i,
   input  logic [IDX_W-1:0]      set_idx_i,
   input  logic                  set_dirty_i,
   input  logic                  clr_ref_en_i,
   input  logic [IDX_W-1:0]      clr_ref_idx_i,
   input  logic                  clr_all_en_i,
   input  logic [IDX_W-1:0]      clr_all_idx_i,
   output logic [NUM_FRAMES-1:0] ref_o,
   output logic [NUM_FRAMES-1:0] dirty_o
);

   generate
      for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
         logic hit_set, hit_clr_ref, hit_clr_all;
         logic ref_q, dirty_q;

         assign hit_set     = set_en_i     && (set_idx_i     == IDX_W'(f));
         assign hit_clr_ref = clr_ref_en_i && (clr_ref_idx_i == IDX_W'(f));
         assign hit_clr_all = clr_all_en_i && (clr_all_idx_i == IDX_W'(f));

         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               ref_q   <= 1'b0;
               dirty_q <= 1'b0;
            end else begin
               if (hit_clr_ref || hit_clr_all) begin
                  ref_q <= 1'b0;
               end else if (hit_set) begin
                  ref_q <= 1'b1;
               end
               if (hit_clr_all) begin
                  dirty_q <= 1'b0;
               end else if (hit_set && set_dirty_i) begin
                  dirty_q <= 1'b1;
               end
            end
         end

         assign ref_o[f]   = ref_q;
         assign dirty_o[f] = dirty_q;
      end
   endgenerate

endmodule

// File: rtl/pfr_class_pick.sv
module pfr_class_pick
   import pfr_pkg::*;
#(
   parameter int unsigned NUM_FRAMES = 8,
   localparam int unsigned IDX_W     = $clog2(NUM_FRAMES)
) (
   input  logic [NUM_FRAMES-1:0] ref_i,
   input  logic [NUM_FRAMES-1:0] dirty_i,
   input  logic [IDX_W-1:0]      start_i,
   output logic [IDX_W-1:0]      pick_o,
   output cand_class_e           class_o
);

   logic [NUM_FRAMES-1:0] m_cold, m_unref, m_clean, mask;

   assign m_cold  = ~ref_i & ~dirty_i;
   assign m_unref = ~ref_i;
   assign m_clean = ~dirty_i;

   always_comb begin
      if (|m_cold) begin
         mask    = m_cold;
         class_o = CL_COLD;
      end else if (|m_unref) begin
         mask    = m_unref;
         class_o = CL_UNREF;
      end else if (|m_clean) begin
         mask    = m_clean;
         class_o = CL_CLEAN;
      end else begin
         mask    = '1;
         class_o = CL_ANY;
      end
   end

   always_comb begin
      logic             found;
      logic [IDX_W-1:0] idx;
      found  = 1'b0;
      pick_o = '0;
      for (int k = 0; k < NUM_FRAMES; k++) begin
         idx = start_i + IDX_W'(k);
         if (!found && mask[idx]) begin
            pick_o = idx;
            found  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/pfr_victim_sel.sv
module pfr_victim_sel
   import pfr_pkg::*;
#(
   parameter int unsigned      NUM_FRAMES = 8,
   parameter int unsigned      LFSR_W     = 16,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   localparam int unsigned     IDX_W      = $clog2(NUM_FRAMES)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             acc_valid_i,
   input  logic [IDX_W-1:0] acc_frame_i,
   input  logic             acc_write_i,
   input  logic             mode_i,
   input  logic             fault_req_i,
   output logic [IDX_W-1:0] victim_o,
   output logic             done_o
);

   generate
      if (NUM_FRAMES < 2 || (NUM_FRAMES & (NUM_FRAMES - 1)) != 0) begin : g_chk_frames
         $error("pfr_victim_sel: NUM_FRAMES must be a power of two, at least 2");
      end
      if (LFSR_W < IDX_W) begin : g_chk_lfsr
         $error("pfr_victim_sel: LFSR_W narrower than the frame index");
      end
   endgenerate

   sel_state_e            state_q, state_d;
   policy_e               mode_q;
   logic [IDX_W-1:0]      ptr_q, ptr_d;
   logic [IDX_W-1:0]      victim_q;
   logic                  done_q;
   logic [NUM_FRAMES-1:0] ref_q, dirty_q;
   logic [LFSR_W-1:0]     lfsr_q;
   logic [IDX_W-1:0]      pick_idx;
   cand_class_e           pick_class;
   logic                  accept;
   logic                  sweep_clr;
   logic                  sel_fire;
   logic [IDX_W-1:0]      sel_idx;

   pfr_lfsr #(
      .WIDTH (LFSR_W),
      .SEED  (LFSR_SEED)
   ) lfsr_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .state_o (lfsr_q)
   );

   pfr_frame_bits #(
      .NUM_FRAMES (NUM_FRAMES)
   ) bits_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .set_en_i      (acc_valid_i),
      .set_idx_i     (acc_frame_i),
      .set_dirty_i   (acc_write_i),
      .clr_ref_en_i  (sweep_clr),
      .clr_ref_idx_i (ptr_q),
      .clr_all_en_i  (sel_fire),
      .clr_all_idx_i (sel_idx),
      .ref_o         (ref_q),
      .dirty_o       (dirty_q)
   );

   pfr_class_pick #(
      .NUM_FRAMES (NUM_FRAMES)
   ) pick_i (
      .ref_i   (ref_q),
      .dirty_i (dirty_q),
      .start_i (lfsr_q[IDX_W-1:0]),
      .pick_o  (pick_idx),
      .class_o (pick_class)
   );

   assign accept = fault_req_i && (state_q == ST_IDLE) && !done_q;

   always_comb begin
      state_d   = state_q;
      ptr_d     = ptr_q;
      sweep_clr = 1'b0;
      sel_fire  = 1'b0;
      sel_idx   = ptr_q;
      case (state_q)
         ST_IDLE: begin
            if (accept) begin
               if (policy_e'(mode_i) == POL_CLASS) begin
                  sel_fire = 1'b1;
                  sel_idx  = pick_idx;
               end else begin
                  state_d = ST_SWEEP;
               end
            end
         end
         ST_SWEEP: begin
            if (ref_q[ptr_q]) begin
               sweep_clr = 1'b1;
               ptr_d     = ptr_q + IDX_W'(1);
            end else begin
               sel_fire = 1'b1;
               sel_idx  = ptr_q;
               state_d  = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
      if (sel_fire) begin
         ptr_d = sel_idx + IDX_W'(1);
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         mode_q   <= POL_SWEEP;
         ptr_q    <= '0;
         victim_q <= '0;
         done_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         ptr_q   <= ptr_d;
         done_q  <= sel_fire;
         if (accept) begin
            mode_q <= policy_e'(mode_i);
         end
         if (sel_fire) begin
            victim_q <= sel_idx;
         end
      end
   end

   assign victim_o = victim_q;
   assign done_o   = done_q;

endmodule

// File: rtl/pfr_victim_sel_chk.sv
module pfr_victim_sel_chk
   import pfr_pkg::*;
#(
   parameter int unsigned NUM_FRAMES = 8,
   localparam int unsigned IDX_W     = $clog2(NUM_FRAMES)
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  acc_valid_i,
   input logic [IDX_W-1:0]      acc_frame_i,
   input logic                  acc_write_i,
   input logic                  mode_i,
   input logic                  fault_req_i,
   input logic [IDX_W-1:0]      victim_o,
   input logic                  done_o,
   input logic                  busy,
   input logic                  mode_q,
   input logic [NUM_FRAMES-1:0] ref_q,
   input logic [NUM_FRAMES-1:0] dirty_q,
   input logic                  clr_ref_en,
   input logic [IDX_W-1:0]      clr_ref_idx,
   input logic                  clr_all_en,
   input logic [IDX_W-1:0]      clr_all_idx
);

   logic [NUM_FRAMES-1:0] ref_prev, dirty_prev;
   logic [IDX_W:0]        sweep_cnt;
   logic                  acc_cleared;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ref_prev   <= '0;
         dirty_prev <= '0;
         sweep_cnt  <= '0;
      end else begin
         ref_prev   <= ref_q;
         dirty_prev <= dirty_q;
         sweep_cnt  <= busy ? sweep_cnt + 1'b1 : '0;
      end
   end

   assign acc_cleared = (clr_ref_en && clr_ref_idx == acc_frame_i) ||
                        (clr_all_en && clr_all_idx == acc_frame_i);

   function automatic int rank_of(input logic r, input logic d);
      return r ? (d ? 3 : 2) : (d ? 1 : 0);
   endfunction

   function automatic int best_rank(input logic [NUM_FRAMES-1:0] r,
                                    input logic [NUM_FRAMES-1:0] d);
      int b = 3;
      for (int i = 0; i < NUM_FRAMES; i++) begin
         if (rank_of(r[i], d[i]) < b) b = rank_of(r[i], d[i]);
      end
      return b;
   endfunction

   // R2
   ref_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && !acc_cleared) |=> ref_q[$past(acc_frame_i)]);

   // R2
   dirty_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && acc_write_i && !acc_cleared) |=> dirty_q[$past(acc_frame_i)]);

   // R5
   sweep_victim_unref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && mode_q == POL_SWEEP) |-> !ref_prev[victim_o]);

   // R7
   class_rank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && mode_q == POL_CLASS) |->
         rank_of(ref_prev[victim_o], dirty_prev[victim_o]) == best_rank(ref_prev, dirty_prev));

   // R6
   sweep_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |-> (sweep_cnt <= (IDX_W+1)'(NUM_FRAMES)));

   // R9
   class_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_req_i && !busy && !done_o && mode_i == POL_CLASS) |=> done_o);

   // R10
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R10
   victim_bits_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!ref_q[victim_o] && !dirty_q[victim_o]));

   // R3
   busy_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && $past(busy) && !done_o) |-> $stable(mode_q));

endmodule

bind pfr_victim_sel pfr_victim_sel_chk #(
   .NUM_FRAMES (NUM_FRAMES)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .acc_valid_i (acc_valid_i),
   .acc_frame_i (acc_frame_i),
   .acc_write_i (acc_write_i),
   .mode_i      (mode_i),
   .fault_req_i (fault_req_i),
   .victim_o    (victim_o),
   .done_o      (done_o),
   .busy        (state_q == pfr_pkg::ST_SWEEP),
   .mode_q      (mode_q),
   .ref_q       (ref_q),
   .dirty_q     (dirty_q),
   .clr_ref_en  (sweep_clr),
   .clr_ref_idx (ptr_q),
   .clr_all_en  (sel_fire),
   .clr_all_idx (sel_idx)
);

// File: tb/pfr_victim_sel_tb.sv
module pfr_victim_sel_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [2:0] acc_frame = '0;
   logic       acc_write = 1'b0;
   logic       mode = 1'b0;
   logic       fault = 1'b0;
   logic [2:0] victim;
   logic       done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [7:0]  m_ref   = '0;
   logic [7:0]  m_dirty = '0;
   int          m_ptr   = 0;
   logic [15:0] m_lfsr;

   always #4 clk = ~clk;

   pfr_victim_sel dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .acc_valid_i (acc_valid),
      .acc_frame_i (acc_frame),
      .acc_write_i (acc_write),
      .mode_i      (mode),
      .fault_req_i (fault),
      .victim_o    (victim),
      .done_o      (done)
   );

   // independent model of the R8 shift register
   always @(posedge clk) begin
      if (!rst_n) m_lfsr <= 16'hACE1;
      else        m_lfsr <= {m_lfsr[14:0], ^(m_lfsr & 16'hB400)};
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   function automatic int class_pick(input logic [7:0] r, input logic [7:0] d, input int start);
      logic [7:0] m;
      if (|(~r & ~d))   m = ~r & ~d;
      else if (|(~r))   m = ~r;
      else if (|(~d))   m = ~d;
      else              m = 8'hFF;
      for (int k = 0; k < 8; k++) begin
         if (m[(start + k) % 8]) return (start + k) % 8;
      end
      return 0;
   endfunction

   task automatic access(input int f, input bit w);
      @(negedge clk);
      acc_valid = 1'b1;
      acc_frame = 3'(f);
      acc_write = w;
      m_ref[f] = 1'b1;
      if (w) m_dirty[f] = 1'b1;
   endtask

   task automatic idle_access();
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   // computes the expected victim and latency, and updates the model
   task automatic expect_fault(input bit cls, input int start, output int v, output int lat);
      if (cls) begin
         v   = class_pick(m_ref, m_dirty, start);
         lat = 1;
      end else begin
         int steps = 1;
         while (m_ref[m_ptr]) begin
            m_ref[m_ptr] = 1'b0;
            m_ptr = (m_ptr + 1) % 8;
            steps++;
         end
         v   = m_ptr;
         lat = steps + 1;
      end
      m_ref[v]   = 1'b0;
      m_dirty[v] = 1'b0;
      m_ptr      = (v + 1) % 8;
   endtask

   task automatic run_fault(input bit cls, input string req);
      int v, lat, exp_lat;
      @(negedge clk);
      acc_valid = 1'b0;
      mode  = cls;
      fault = 1'b1;
      expect_fault(cls, int'(m_lfsr[2:0]), v, exp_lat);
      @(negedge clk);
      fault = 1'b0;
      lat = 1;
      while (!done && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      check(done, {req, " done seen"}, int'(done), 1);
      check(victim == 3'(v), {req, " victim"}, int'(victim), v);
      check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
      @(negedge clk);
      check(!done, "R10 done single pulse", int'(done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
      end
   end

   initial begin
      int seed_set;
      seed_set = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset outputs
      check(!done, "R1 done low after reset", int'(done), 0);
      check(victim == 3'd0, "R1 victim zero after reset", int'(victim), 0);
      // R1 and R5: clean state, pointer at 0 gives frame 0 after one step
      run_fault(1'b0, "R1 sweep from reset");

      // R2: reads mark referenced; untouched frame 6 is the only cold frame
      for (int f = 0; f < 8; f++) if (f != 6) access(f, 1'b0);
      idle_access();
      run_fault(1'b1, "R2 read sets ref, R7 cold class");

      // R2: all read, all but 4 written; only frame 4 stays clean
      for (int f = 0; f < 8; f++) access(f, 1'b0);
      for (int f = 0; f < 8; f++) if (f != 4) access(f, 1'b1);
      idle_access();
      run_fault(1'b1, "R2 write sets dirty, R7 clean class");

      // R7 and R10: every frame referenced and dirty, then the victim is the sole cold frame
      for (int f = 0; f < 8; f++) access(f, 1'b1);
      idle_access();
      run_fault(1'b1, "R8 any class pick");
      run_fault(1'b1, "R10 victim bits cleared");

      // R4 and R6: every frame referenced forces the longest sweep
      for (int f = 0; f < 8; f++) access(f, 1'b0);
      idle_access();
      run_fault(1'b0, "R6 full sweep");

      // R4 and R5: two referenced frames ahead of the pointer, dirty frames ignored
      access((m_ptr) % 8, 1'b0);
      access((m_ptr + 1) % 8, 1'b1);
      idle_access();
      run_fault(1'b0, "R4 skip referenced, R5 first clear");

      // R3: request during a sweep is dropped
      begin
         int v, lat, cnt, seen;
         for (int f = 0; f < 8; f++) access(f, 1'b0);
         idle_access();
         @(negedge clk);
         mode  = 1'b0;
         fault = 1'b1;
         expect_fault(1'b0, 0, v, lat);
         cnt  = 0;
         seen = 0;
         for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (done) begin
               cnt++;
               seen = int'(victim);
            end
            fault = (i == 1);
            mode  = (i == 1);
         end
         fault = 1'b0;
         check(cnt == 1, "R3 busy request ignored", cnt, 1);
         check(seen == v, "R3 sweep victim kept", seen, v);
      end

      // R5, R7, R8: constrained random mixes
      for (int round = 0; round < 60; round++) begin
         int n_acc;
         bit cls;
         n_acc = int'($urandom_range(0, 12));
         for (int a = 0; a < n_acc; a++) begin
            access(int'($urandom_range(0, 7)), bit'($urandom_range(0, 1)));
         end
         idle_access();
         cls = bit'($urandom_range(0, 1));
         run_fault(cls, cls ? "R8 random class pick" : "R5 random sweep");
      end

      finished = 1'b1;
      summary();
   end

endmodule